// File: doc/BRIEF.md
# Thirty-two source interrupt controller

This block gathers thirty-two interrupt lines from peripherals and turns them into two processor request lines: a normal request and a critical request. For each source, software chooses whether it is enabled, whether it is sensed by level or by edge, which polarity counts as active, and which of the two request lines it drives. Detected events are latched in a status word. Software clears that word by writing ones.

Software reaches the controller through a small register bus: one select strobe, a write flag, a three-bit offset and a 32-bit data word. Every access is acknowledged one cycle later. A read-only masked word shows which enabled sources are pending. A read of zero from it means nothing enabled is waiting. Controllers can be chained by wiring one controller's request output into a source input of another.

Top module: `irqc_top`

## Requirements
- R1: Source n (input `src_i[n]`) occupies bit 31−n of every register word, so source 0 is the most significant bit and source 31 is bit 0.
- R2: Reset clears the enable, critical-select, polarity and trigger words to zero and holds both request outputs low.
- R3: Trigger bit 0 selects level sensing and 1 selects edge sensing. Polarity bit 1 means active-high level or rising edge, and polarity bit 0 means active-low level or falling edge. An edge source latches only on a transition into its active level.
- R4: Writing the status word (offset 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A level-sensed status bit stays set after a clear while its input is still at its active level, including when the source is disabled.
- R6: An edge-sensed status bit stays set after its input returns to inactive, until software clears it.
- R7: Status bits latch whether or not the source is enabled. The masked word (offset 6) reads status AND enable. Writes to offset 6 have no effect.
- R8: A critical-select bit of 1 steers an enabled pending source to `irq_crit_o`, and 0 steers it to `irq_norm_o`. Both outputs are registered, so they change one cycle after the masked status or the steering changes.
- R9: When a new event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R10: Register offsets are: status 0, enable 2, critical select 3, polarity 4, trigger 5, masked status 6. `bus_ack_o` is high exactly in the cycle after a cycle with `bus_sel_i` high. Read data is valid with the ack. Unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt inputs, indexed by source number |
| bus_sel_i | input | 1 | Register access request, one cycle per access |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with the ack |
| bus_ack_o | output | 1 | Access acknowledge |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
Some properties are checked on every cycle: set status bits stay set unless cleared, a fresh event overrides a clear, a clear with no event empties the bit, the ack follows each request by one cycle, and a fully disabled controller never raises a request. Other behaviour can only be shown by bench scenarios: the reversed bit order, polarity and edge selection seen through the synchronizer, a level bit refusing to clear while its input is active, the read-only masked word, and the one-cycle lag of the request outputs after a steering change.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int unsigned N_SRC       = 32;
    localparam int unsigned ADDR_W      = 3;
    localparam int unsigned SYNC_STAGES = 2;

    typedef logic [N_SRC-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT   = 3'd0,
        REG_ENAB   = 3'd2,
        REG_CRIT   = 3'd3,
        REG_POL    = 3'd4,
        REG_TRIG   = 3'd5,
        REG_MASKED = 3'd6
    } reg_addr_e;

    typedef struct packed {
        word_t enable;
        word_t crit;
        word_t polarity;
        word_t edge_mode;
    } irqc_cfg_t;

    // Source n maps to register bit N_SRC-1-n.
    function automatic word_t src_to_word(input word_t v);
        word_t w;
        for (int n = 0; n < int'(N_SRC); n++) begin
            w[N_SRC-1-n] = v[n];
        end
        return w;
    endfunction
endpackage

// File: rtl/irqc_detect.sv
`timescale 1ns/1ps
module irqc_detect #(
    parameter int unsigned N      = irqc_pkg::N_SRC,
    parameter int unsigned STAGES = irqc_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] polarity_i,
    input  logic [N-1:0] edge_mode_i,
    output logic [N-1:0] event_o
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < int'(N); g++) begin : g_src
        logic [CHAIN_W-1:0] chain;
        logic               act_now;
        logic               act_before;

        // chain[STAGES-1] is the synchronized value, chain[STAGES] its previous value
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[CHAIN_W-2:0], line_i[g]};
            end
        end

        always_comb begin
            act_now    = chain[STAGES-1] ~^ polarity_i[g];
            act_before = chain[STAGES]   ~^ polarity_i[g];
            event_o[g] = edge_mode_i[g] ? (act_now & ~act_before) : act_now;
        end
    end
endmodule

// File: rtl/irqc_status.sv
`timescale 1ns/1ps
module irqc_status #(
    parameter int unsigned N = irqc_pkg::N_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] event_i,
    input  logic [N-1:0] clear_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clear_i) | event_i;
        end
    end

    assign pend_o = pend_q;

    AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clear_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (event_i != '0) |=> ((pend_q & $past(event_i)) == $past(event_i))); // R9

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        ((clear_i & ~event_i) != '0) |=> ((pend_q & $past(clear_i & ~event_i)) == '0)); // R4
endmodule

// File: rtl/irqc_regfile.sv
`timescale 1ns/1ps
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int unsigned N  = irqc_pkg::N_SRC,
    parameter int unsigned AW = irqc_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [N-1:0]  wdata_i,
    output logic [N-1:0]  rdata_o,
    output logic          ack_o,
    input  logic [N-1:0]  pend_i,
    output logic [N-1:0]  clear_o,
    output irqc_cfg_t     cfg_o
);
    irqc_cfg_t    cfg_q;
    logic [N-1:0] rd_word;
    logic [N-1:0] rdata_q;
    logic         ack_q;
    logic         wr_en;

    assign wr_en   = sel_i & wr_i;
    assign clear_o = (wr_en && addr_i == REG_STAT) ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr_i)
                REG_ENAB: cfg_q.enable    <= wdata_i;
                REG_CRIT: cfg_q.crit      <= wdata_i;
                REG_POL:  cfg_q.polarity  <= wdata_i;
                REG_TRIG: cfg_q.edge_mode <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr_i)
            REG_STAT:   rd_word = pend_i;
            REG_ENAB:   rd_word = cfg_q.enable;
            REG_CRIT:   rd_word = cfg_q.crit;
            REG_POL:    rd_word = cfg_q.polarity;
            REG_TRIG:   rd_word = cfg_q.edge_mode;
            REG_MASKED: rd_word = pend_i & cfg_q.enable;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= sel_i;
            if (sel_i && !wr_i) begin
                rdata_q <= rd_word;
            end
        end
    end

    assign ack_o   = ack_q;
    assign rdata_o = rdata_q;
    assign cfg_o   = cfg_q;

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        sel_i |=> ack_o); // R10

    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> !ack_o); // R10
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = irqc_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [N_SRC-1:0]  bus_wdata_i,
    output logic [N_SRC-1:0]  bus_rdata_o,
    output logic              bus_ack_o,
    output logic              irq_norm_o,
    output logic              irq_crit_o
);
    word_t     line_w;
    word_t     event_w;
    word_t     pend_w;
    word_t     clear_w;
    word_t     masked_w;
    irqc_cfg_t cfg;
    logic      norm_q;
    logic      crit_q;

    assign line_w = src_to_word(src_i);

    irqc_detect #(.N(N_SRC), .STAGES(SYNC_DEPTH)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line_w),
        .polarity_i  (cfg.polarity),
        .edge_mode_i (cfg.edge_mode),
        .event_o     (event_w)
    );

    irqc_status #(.N(N_SRC)) u_status (
        .clk     (clk),
        .rst     (rst),
        .event_i (event_w),
        .clear_i (clear_w),
        .pend_o  (pend_w)
    );

    irqc_regfile #(.N(N_SRC), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .ack_o   (bus_ack_o),
        .pend_i  (pend_w),
        .clear_o (clear_w),
        .cfg_o   (cfg)
    );

    assign masked_w = pend_w & cfg.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            norm_q <= 1'b0;
            crit_q <= 1'b0;
        end else begin
            norm_q <= |(masked_w & ~cfg.crit);
            crit_q <= |(masked_w & cfg.crit);
        end
    end

    assign irq_norm_o = norm_q;
    assign irq_crit_o = crit_q;

    AST_DISABLED_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg.enable == '0) |=> (!irq_norm_o && !irq_crit_o)); // R7

    AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pend_w == '0) |=> (!irq_norm_o && !irq_crit_o)); // R8
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src;
    logic        sel, wr;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        ack, irq_n, irq_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [2:0] A_ST = 3'd0, A_EN = 3'd2, A_CR = 3'd3,
                           A_PR = 3'd4, A_TR = 3'd5, A_MS = 3'd6;

    always #2.5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst(rst), .src_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_ack_o(ack),
        .irq_norm_o(irq_n), .irq_crit_o(irq_c)
    );

    function automatic logic [31:0] rev(input logic [31:0] v);
        logic [31:0] w;
        for (int n = 0; n < 32; n++) w[31-n] = v[n];
        return w;
    endfunction

    function automatic logic [31:0] level_hits(input logic [31:0] s, input logic [31:0] pol,
                                               input logic [31:0] trg);
        return ~trg & ~(rev(s) ^ pol);
    endfunction

    function automatic logic [31:0] edge_hits(input logic [31:0] s_new, input logic [31:0] flip,
                                              input logic [31:0] pol, input logic [31:0] trg);
        return trg & rev(flip) & ~(rev(s_new) ^ pol);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(posedge clk); @(negedge clk);
        sel = 1'b0;
        chk("R10 ack", {31'd0, ack}, 32'd1);
        d = rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pol, trg, en, cr, s2, flip, sr_exp;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; src = '1; sel = 0; wr = 0; addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        chk("R2 outputs in reset", {30'd0, irq_n, irq_c}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 no ack when idle", {31'd0, ack}, 32'd0);
        expect_reg("R2 enable reset", A_EN, 32'd0);
        expect_reg("R2 crit reset", A_CR, 32'd0);
        expect_reg("R2 polarity reset", A_PR, 32'd0);
        expect_reg("R2 trigger reset", A_TR, 32'd0);
        expect_reg("R7 masked zero with no enables", A_MS, 32'd0);
        chk("R2 outputs after reset", {30'd0, irq_n, irq_c}, 32'd0);
        expect_reg("R10 unused offset reads zero", 3'd1, 32'd0);

        // Directed: bit order and edge hold, rising edges
        src = '0; settle();
        bus_wr(A_PR, '1); bus_wr(A_TR, '1);
        bus_wr(A_ST, '1); settle();
        expect_reg("R4 clear all", A_ST, 32'd0);
        src[0] = 1'b1; settle();
        expect_reg("R1 source 0 is bit 31", A_ST, 32'h8000_0000);
        src[0] = 1'b0; settle();
        expect_reg("R6 edge bit held", A_ST, 32'h8000_0000);
        bus_wr(A_ST, 32'h7fff_ffff); settle();
        expect_reg("R4 zero leaves bit", A_ST, 32'h8000_0000);
        bus_wr(A_ST, 32'h8000_0000); settle();
        expect_reg("R4 one clears bit", A_ST, 32'd0);
        src[31] = 1'b1; settle();
        expect_reg("R1 source 31 is bit 0", A_ST, 32'h0000_0001);

        // Routing and output latency
        bus_wr(A_EN, 32'h0000_0001); settle();
        chk("R8 normal route", {30'd0, irq_n, irq_c}, 32'd2);
        expect_reg("R7 masked status", A_MS, 32'h0000_0001);
        bus_wr(A_MS, 32'hdead_beef);
        expect_reg("R7 masked write ignored", A_MS, 32'h0000_0001);
        bus_wr(A_CR, 32'h0000_0001);
        chk("R8 output registered (old)", {30'd0, irq_n, irq_c}, 32'd2);
        @(negedge clk);
        chk("R8 critical route", {30'd0, irq_n, irq_c}, 32'd1);
        bus_wr(A_EN, 32'd0); bus_wr(A_CR, 32'd0);
        src = '0; settle();
        bus_wr(A_ST, '1); settle();

        // Level bit cannot be cleared while active, even disabled
        bus_wr(A_TR, 32'd0); settle();
        src[4] = 1'b1; settle();
        expect_reg("R7 latched while disabled", A_ST, 32'h0800_0000);
        bus_wr(A_ST, '1); settle();
        expect_reg("R5 level bit survives clear", A_ST, 32'h0800_0000);
        src[4] = 1'b0; settle();
        expect_reg("R5 level bit latched", A_ST, 32'h0800_0000);
        bus_wr(A_ST, '1); settle();
        expect_reg("R4 level clears when inactive", A_ST, 32'd0);

        // Event coinciding with clear
        bus_wr(A_TR, '1);
        src[5] = 1'b1; settle(); src[5] = 1'b0; settle();
        expect_reg("R6 edge set", A_ST, 32'h0400_0000);
        src[5] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        bus_wr(A_ST, 32'h0400_0000);
        expect_reg("R9 event wins over clear", A_ST, 32'h0400_0000);
        bus_wr(A_ST, 32'h0400_0000); settle();
        expect_reg("R4 clear without event", A_ST, 32'd0);

        // Falling edge
        bus_wr(A_PR, 32'hfdff_ffff);
        src[6] = 1'b1; settle();
        expect_reg("R3 rise ignored for falling edge", A_ST, 32'd0);
        src[6] = 1'b0; settle();
        expect_reg("R3 falling edge latched", A_ST, 32'h0200_0000);

        // Random phase
        for (int it = 0; it < 40; it++) begin
            logic [31:0] d;
            pol = $urandom; trg = $urandom; en = $urandom; cr = $urandom;
            bus_wr(A_PR, pol); bus_wr(A_TR, trg); bus_wr(A_EN, en); bus_wr(A_CR, cr);
            src = $urandom; settle();
            bus_wr(A_ST, '1); settle();
            sr_exp = level_hits(src, pol, trg);
            expect_reg("R3 R5 random level state", A_ST, sr_exp);
            flip = $urandom; s2 = src ^ flip; src = s2; settle();
            sr_exp = sr_exp | level_hits(s2, pol, trg) | edge_hits(s2, flip, pol, trg);
            expect_reg("R3 R6 random after toggle", A_ST, sr_exp);
            expect_reg("R7 random masked", A_MS, sr_exp & en);
            d = {30'd0, |(sr_exp & en & ~cr), |(sr_exp & en & cr)};
            chk("R8 random outputs", {30'd0, irq_n, irq_c}, d);
            bus_wr(A_ST, '1); settle();
            expect_reg("R4 R5 random after clear", A_ST, level_hits(s2, pol, trg));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule